// File: doc/BRIEF.md
# Timer Capture Register with Atomic Byte Access

This block holds a 16-bit capture register attached to a free-running 16-bit timer count. When a capture event arrives, the register takes a snapshot of the count. The event can come from one of two single-cycle strobes: an external capture pin strobe or an internal comparator strobe. A select input chooses which one is used. Edge selection and noise filtering happen upstream of the block, so each strobe is already one clock wide.

Software sees the register as two bytes on an 8-bit bus, at a low-byte address and a high-byte address. An 8-bit staging latch makes 16-bit transfers atomic:
- Reading the low byte parks the matching high byte in the latch. A later high-byte read returns the parked byte.
- Writing the high byte only fills the latch. A later low-byte write loads all 16 bits at once.

The staging latch is shared with the timer's other 16-bit registers. Those registers can load it through peer strobes, and its value is exported so they can commit from it.

The register can also serve as the timer's TOP value. In that mode, capture events are ignored and the register keeps whatever software last wrote.

Top module: `tcap_reg16`

## Requirements
- R1: After reset the capture register and the staging latch are both zero, and a low-byte read returns 0x00.
- R2: With `src_sel`=0, a one-cycle `cap_pin` strobe loads `cnt_val` into the register; the new value is visible on `cap_val` after that clock edge. A `cmp_evt` strobe has no effect in this setting.
- R3: With `src_sel`=1, a `cmp_evt` strobe loads `cnt_val`. A `cap_pin` strobe has no effect in this setting.
- R4: A bus read at `ADDR_LO` returns bits 7:0 of the register in the same cycle. At that clock edge it also copies bits 15:8 into the staging latch.
- R5: A bus read at `ADDR_HI` returns the staging latch, not the live register. A capture that lands between a low read and the following high read therefore cannot tear the 16-bit value.
- R6: A bus write at `ADDR_HI` loads only the staging latch and leaves the register unchanged.
- R7: A bus write at `ADDR_LO` loads the register with {staging latch, written byte} in a single clock edge.
- R8: When a low-byte write and a selected capture event occur in the same cycle, the write wins.
- R9: While `cap_is_top`=1, capture events are ignored and the register holds its value. CPU byte writes still update it.
- R10: The staging latch is shared with the timer's other 16-bit registers:
  - `peer_rd_lo` loads it from `peer_hi`.
  - `peer_wr_hi` loads it from `bus_wdata`.
  - Its value is exported on `temp_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current timer count |
| cap_pin | input | 1 | External capture strobe, one cycle wide |
| cmp_evt | input | 1 | Comparator capture strobe, one cycle wide |
| src_sel | input | 1 | Event source: 0 = pin, 1 = comparator |
| cap_is_top | input | 1 | Register is used as TOP; captures are blocked |
| bus_addr | input | 8 | Bus byte address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational for the current read |
| peer_rd_lo | input | 1 | Another 16-bit register's low byte is being read |
| peer_hi | input | 8 | High byte of that other register |
| peer_wr_hi | input | 1 | Another 16-bit register's high byte is being written |
| temp_hi | output | 8 | Shared staging latch value |
| cap_val | output | 16 | Capture register value, also the TOP value |

## Verification
The main capture function is exercised three ways:
- Each source is strobed while selected and while not selected. This separates a correct multiplexer from one that ORs the two sources or has the select inverted.
- A capture is placed between a low-byte read and the following high-byte read. This tells a latched high byte apart from a live one.
- A capture lands in the same cycle as a low-byte write, and captures are attempted in TOP mode. These distinguish write priority and blocking from a design that lets events through.

Loading the staging latch through the peer strobes and then committing with a low write shows that the latch is truly shared.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_RD_LO = 3'd1,
        ACC_RD_HI = 3'd2,
        ACC_WR_LO = 3'd3,
        ACC_WR_HI = 3'd4
    } acc_e;

endpackage

// File: rtl/tcap_bus_dec.sv
module tcap_bus_dec
    import tcap_pkg::*;
#(
    parameter int AW      = 8,
    parameter int ADDR_LO = 8'h86,
    parameter int ADDR_HI = 8'h87
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output acc_e          acc
);
    localparam logic [AW-1:0] LO_A = AW'(ADDR_LO);
    localparam logic [AW-1:0] HI_A = AW'(ADDR_HI);

    logic hit_lo;
    logic hit_hi;

    assign hit_lo = (addr == LO_A);
    assign hit_hi = (addr == HI_A);

    always_comb begin
        acc = ACC_NONE;
        if (wr) begin
            if (hit_lo)      acc = ACC_WR_LO;
            else if (hit_hi) acc = ACC_WR_HI;
        end else if (rd) begin
            if (hit_lo)      acc = ACC_RD_LO;
            else if (hit_hi) acc = ACC_RD_HI;
        end
    end
endmodule

// File: rtl/tcap_evt_sel.sv
module tcap_evt_sel #(
    parameter int NUM_SRC = 2,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic [SEL_W-1:0]   sel,
    input  logic               blocked,
    output logic               fire
);
    logic picked;

    generate
        if (NUM_SRC == 1) begin : g_single
            assign picked = evt_in[0];
        end else begin : g_multi
            always_comb begin
                picked = 1'b0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (sel == SEL_W'(i)) picked = evt_in[i];
                end
            end
        end
    endgenerate

    assign fire = picked & ~blocked;
endmodule

// File: rtl/tcap_core.sv
module tcap_core
    import tcap_pkg::*;
#(
    parameter int DW  = 8,
    localparam int RW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_e          acc,
    input  logic [DW-1:0] wdata,
    input  logic          fire,
    input  logic [RW-1:0] cnt,
    input  logic          peer_rd_lo,
    input  logic [DW-1:0] peer_hi,
    input  logic          peer_wr_hi,
    output logic [RW-1:0] cap_q_o,
    output logic [DW-1:0] tmp_q_o,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic [DW-1:0] tmp;
        logic [RW-1:0] cap;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (acc)
            ACC_RD_LO: st_d.tmp = st_q.cap[RW-1:DW];
            ACC_WR_HI: st_d.tmp = wdata;
            ACC_WR_LO: st_d.cap = {st_q.tmp, wdata};
            default: begin
                if (peer_wr_hi)      st_d.tmp = wdata;
                else if (peer_rd_lo) st_d.tmp = peer_hi;
            end
        endcase
        if (fire && (acc != ACC_WR_LO)) st_d.cap = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (acc)
            ACC_RD_LO: rdata = st_q.cap[DW-1:0];
            ACC_RD_HI: rdata = st_q.tmp;
            default:   rdata = '0;
        endcase
    end

    assign cap_q_o = st_q.cap;
    assign tmp_q_o = st_q.tmp;
endmodule

// File: rtl/tcap_reg16.sv
module tcap_reg16
    import tcap_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int ADDR_LO = 8'h86,
    parameter int ADDR_HI = 8'h87,
    localparam int RW     = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] cnt_val,
    input  logic          cap_pin,
    input  logic          cmp_evt,
    input  logic          src_sel,
    input  logic          cap_is_top,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          peer_rd_lo,
    input  logic [DW-1:0] peer_hi,
    input  logic          peer_wr_hi,
    output logic [DW-1:0] temp_hi,
    output logic [RW-1:0] cap_val
);
    acc_e acc;
    logic fire;

    tcap_bus_dec #(
        .AW(AW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
    ) dec_i (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .acc(acc)
    );

    tcap_evt_sel #(.NUM_SRC(2)) sel_i (
        .evt_in ({cmp_evt, cap_pin}),
        .sel    (src_sel),
        .blocked(cap_is_top),
        .fire   (fire)
    );

    tcap_core #(.DW(DW)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .wdata     (bus_wdata),
        .fire      (fire),
        .cnt       (cnt_val),
        .peer_rd_lo(peer_rd_lo),
        .peer_hi   (peer_hi),
        .peer_wr_hi(peer_wr_hi),
        .cap_q_o   (cap_val),
        .tmp_q_o   (temp_hi),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/tcap_reg16_chk.sv
module tcap_reg16_chk #(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int ADDR_LO = 8'h86,
    parameter int ADDR_HI = 8'h87,
    localparam int RW     = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic [RW-1:0] cnt_val,
    input logic          cap_pin,
    input logic          cmp_evt,
    input logic          src_sel,
    input logic          cap_is_top,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] temp_hi,
    input logic [RW-1:0] cap_val
);
    logic wr_lo, wr_hi, rd_lo, rd_hi, ev;
    assign wr_lo = bus_wr && (bus_addr == AW'(ADDR_LO));
    assign wr_hi = bus_wr && (bus_addr == AW'(ADDR_HI));
    assign rd_lo = bus_rd && !bus_wr && (bus_addr == AW'(ADDR_LO));
    assign rd_hi = bus_rd && !bus_wr && (bus_addr == AW'(ADDR_HI));
    assign ev    = (src_sel ? cmp_evt : cap_pin) && !cap_is_top;

    p_pin_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel && cap_pin && !cap_is_top && !wr_lo) |=> cap_val == $past(cnt_val));
    p_cmp_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && cmp_evt && !cap_is_top && !wr_lo) |=> cap_val == $past(cnt_val));
    p_lo_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> temp_hi == $past(cap_val[RW-1:DW]));
    p_hi_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |-> bus_rdata == temp_hi);
    p_hi_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !ev) |=> (temp_hi == $past(bus_wdata)) && $stable(cap_val));
    p_lo_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cap_val == {$past(temp_hi), $past(bus_wdata)});
    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && ev) |=> cap_val[DW-1:0] == $past(bus_wdata));
    p_top_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_is_top && !wr_lo) |=> $stable(cap_val));
endmodule

bind tcap_reg16 tcap_reg16_chk #(
    .AW(AW), .DW(DW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_pin(cap_pin),
    .cmp_evt(cmp_evt), .src_sel(src_sel), .cap_is_top(cap_is_top),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .temp_hi(temp_hi),
    .cap_val(cap_val)
);

// File: tb/tcap_reg16_tb_top.sv
module tcap_reg16_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] A_LO = 8'h86;
    localparam logic [7:0] A_HI = 8'h87;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cap_pin = 1'b0, cmp_evt = 1'b0, src_sel = 1'b0, cap_is_top = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        peer_rd_lo = 1'b0, peer_wr_hi = 1'b0;
    logic [7:0]  peer_hi = '0;
    logic [7:0]  temp_hi;
    logic [15:0] cap_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcap_reg16 dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_pin(cap_pin),
        .cmp_evt(cmp_evt), .src_sel(src_sel), .cap_is_top(cap_is_top),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .peer_rd_lo(peer_rd_lo), .peer_hi(peer_hi), .peer_wr_hi(peer_wr_hi),
        .temp_hi(temp_hi), .cap_val(cap_val)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(logic [7:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bread(logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic pulse_pin(logic [15:0] c);
        cnt_val = c; cap_pin = 1'b1;
        tick();
        cap_pin = 1'b0;
    endtask

    task automatic pulse_cmp(logic [15:0] c);
        cnt_val = c; cmp_evt = 1'b1;
        tick();
        cmp_evt = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 cap_val", cap_val, 16'h0000);
        chk("R1 temp_hi", {8'h0, temp_hi}, 16'h0000);
        bread(A_LO, d);
        chk("R1 low read", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_pin_src();
        src_sel = 1'b0;
        pulse_pin(16'h1234);
        chk("R2 pin capture", cap_val, 16'h1234);
        pulse_cmp(16'h5555);
        chk("R2 comparator ignored", cap_val, 16'h1234);
    endtask

    task automatic t_cmp_src();
        src_sel = 1'b1;
        pulse_cmp(16'hBEEF);
        chk("R3 comparator capture", cap_val, 16'hBEEF);
        pulse_pin(16'h1111);
        chk("R3 pin ignored", cap_val, 16'hBEEF);
    endtask

    task automatic t_atomic_read();
        logic [7:0] d;
        bread(A_LO, d);
        chk("R4 low byte", {8'h0, d}, 16'h00EF);
        chk("R4 latch loaded", {8'h0, temp_hi}, 16'h00BE);
        pulse_cmp(16'h4321);
        bread(A_HI, d);
        chk("R5 latched high", {8'h0, d}, 16'h00BE);
        bread(A_LO, d);
        chk("R5 new low", {8'h0, d}, 16'h0021);
        bread(A_HI, d);
        chk("R5 new high", {8'h0, d}, 16'h0043);
    endtask

    task automatic t_atomic_write();
        bwrite(A_HI, 8'hA5);
        chk("R6 latch only", {8'h0, temp_hi}, 16'h00A5);
        chk("R6 register kept", cap_val, 16'h4321);
        bwrite(A_LO, 8'h3C);
        chk("R7 commit", cap_val, 16'hA53C);
    endtask

    task automatic t_race();
        bwrite(A_HI, 8'h77);
        bus_addr = A_LO; bus_wdata = 8'h88; bus_wr = 1'b1;
        cnt_val = 16'h9999; cmp_evt = 1'b1;
        tick();
        bus_wr = 1'b0; cmp_evt = 1'b0;
        chk("R8 write wins", cap_val, 16'h7788);
    endtask

    task automatic t_top_mode();
        cap_is_top = 1'b1;
        pulse_cmp(16'h0F0F);
        chk("R9 comparator blocked", cap_val, 16'h7788);
        src_sel = 1'b0;
        pulse_pin(16'hF0F0);
        chk("R9 pin blocked", cap_val, 16'h7788);
        bwrite(A_HI, 8'h12);
        bwrite(A_LO, 8'h34);
        chk("R9 write in top mode", cap_val, 16'h1234);
        cap_is_top = 1'b0;
    endtask

    task automatic t_peer();
        peer_hi = 8'hC3; peer_rd_lo = 1'b1;
        tick();
        peer_rd_lo = 1'b0;
        chk("R10 peer read latch", {8'h0, temp_hi}, 16'h00C3);
        bwrite(A_LO, 8'h01);
        chk("R10 commit from peer latch", cap_val, 16'hC301);
        bus_wdata = 8'h5A; peer_wr_hi = 1'b1;
        tick();
        peer_wr_hi = 1'b0;
        chk("R10 peer write latch", {8'h0, temp_hi}, 16'h005A);
        chk("R10 register kept", cap_val, 16'hC301);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_pin_src();
        t_cmp_src();
        t_atomic_read();
        t_atomic_write();
        t_race();
        t_top_mode();
        t_peer();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule